// File: doc/BRIEF.md
# SOF Interval Timer with Coherent Byte Readout

This block counts peripheral-clock cycles between received USB start-of-frame (SOF) packets. It raises a sticky alarm when the gap grows past a programmable limit, so a lost frame stream can be detected. Packet decoding happens elsewhere. The block sees only a one-cycle `sof_pulse` that the decoder produces for each good SOF.

Plain control pins start, freeze and zero the 16-bit count. They also enable restart-on-SOF and clear the alarm. Software reaches the count over a byte-wide register port with a high-byte register and a low-byte register. A high-byte read latches the live low byte in the same cycle, and the low-byte read returns that latch. Two byte reads therefore always return one coherent 16-bit sample, even while the counter is running. Either byte can be written to preset the count.

The register port has no handshake: an access completes in the cycle it is presented. Read data is combinational from the address and is driven to zero when no read is in progress. No data stream crosses this block, so it has no valid/ready interface and no back-pressure.

Top module: `sof_interval_timer`

## Requirements
- R1: After reset the count is 0, the low-byte latch is 0 and `sof_missing` is 0.
- R2: While `ctl_run` is 1 the count rises by one per clock. While `ctl_run` is 0 the count holds its value.
- R3: `ctl_clear` zeroes the count on the next edge. It overrides register writes, SOF restart and counting.
- R4: The count saturates at 0xFFFF and never wraps to zero by counting.
- R5: A read at address 0 (`bus_en`=1, `bus_we`=0) returns count bits 15:8 and copies count bits 7:0 into the latch on the same edge. `bus_rdata` is 0 when no read is active.
- R6: A read at address 1 returns the latch contents, not the live low byte. A high-then-low read pair yields the count as it stood at the high-byte read.
- R7: A write at address 0 loads count bits 15:8, and a write at address 1 loads bits 7:0. The other byte is unchanged, and there is no increment in that cycle. A write overrides SOF restart.
- R8: A `sof_pulse` while `ctl_auto` is 1 zeroes the count on the next edge. With `ctl_auto` at 0 the pulse has no effect on the count.
- R9: `sof_missing` becomes 1 on the edge after a cycle in which `ctl_run` is 1 and the count is at least `sof_limit`. It then stays 1, including across SOF pulses.
- R10: `miss_clr` drops `sof_missing` on the next edge and wins over a simultaneous set condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_run | input | 1 | Count enable |
| ctl_clear | input | 1 | Zero the count |
| ctl_auto | input | 1 | Restart the count on each SOF |
| sof_pulse | input | 1 | One-cycle SOF-received strobe |
| sof_limit | input | 16 | Gap threshold for the alarm |
| miss_clr | input | 1 | Clear the sticky alarm |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = high byte, 1 = low byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| sof_missing | output | 1 | Sticky SOF-gap alarm |

## Verification
The embedded properties check the following on every cycle:
- clear, hold, write and restart each produce the right next count;
- the counter stays at 0xFFFF once saturated;
- the latch equals the low byte seen at the high-byte read;
- the alarm sets, stays set and clears as specified.

The bench scenarios show what a single-cycle property cannot. These are the byte-crossing counts over hundreds of cycles and a coherent two-byte read taken while the counter rolls from 0x12FF to 0x1300. They also cover the exact edge at which the alarm fires against the limit, and the alarm staying low while SOFs keep arriving inside the window.

// File: rtl/sof_tmr_pkg.sv
package sof_tmr_pkg;
  localparam int unsigned SOF_BYTE_W = 8;

  typedef enum logic {
    REG_HI = 1'b0,
    REG_LO = 1'b1
  } sof_reg_e;
endpackage

// File: rtl/sof_cnt_core.sv
module sof_cnt_core #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              restart,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr_hi) begin
      cnt[CNT_W-1:BYTE_W] <= wdata;
    end else if (wr_lo) begin
      cnt[BYTE_W-1:0] <= wdata;
    end else if (restart) begin
      cnt <= '0;
    end else if (run && !at_max) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !wr_hi && !wr_lo && !restart) |=> $stable(cnt));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr && !wr_hi && !wr_lo && !restart) |=> (cnt == CNT_MAX));

  // R7
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !clr) |=> (cnt[CNT_W-1:BYTE_W] == $past(wdata))
                        && (cnt[BYTE_W-1:0] == $past(cnt[BYTE_W-1:0])));

  // R7
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && !clr) |=> (cnt[BYTE_W-1:0] == $past(wdata))
                                  && (cnt[CNT_W-1:BYTE_W] == $past(cnt[CNT_W-1:BYTE_W])));

  // R8
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !clr && !wr_hi && !wr_lo) |=> (cnt == '0));
endmodule

// File: rtl/sof_miss_det.sv
module sof_miss_det #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] limit,
  input  logic             flag_clr,
  output logic             flag
);
  logic gap_hit;
  assign gap_hit = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end else if (gap_hit) begin
      flag <= 1'b1;
    end
  end

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt >= limit) && !flag_clr) |=> flag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/sof_byte_port.sv
module sof_byte_port
  import sof_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic              rd_hi;
  logic              rd_lo;
  logic [BYTE_W-1:0] lo_hold;
  sof_reg_e          sel;

  assign sel   = sof_reg_e'(bus_addr);
  assign rd_hi = bus_en && !bus_we && (sel == REG_HI);
  assign rd_lo = bus_en && !bus_we && (sel == REG_LO);
  assign wr_hi = bus_en && bus_we && (sel == REG_HI);
  assign wr_lo = bus_en && bus_we && (sel == REG_LO);
  assign wdata = bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold <= '0;
    end else if (rd_hi) begin
      lo_hold <= cnt[BYTE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hi) begin
      rdata = cnt[CNT_W-1:BYTE_W];
    end else if (rd_lo) begin
      rdata = lo_hold;
    end
  end

  // R5
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (lo_hold == $past(cnt[BYTE_W-1:0])));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |=> $stable(lo_hold));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en || bus_we) |-> (rdata == '0));
endmodule

// File: rtl/sof_interval_timer.sv
module sof_interval_timer #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_run,
  input  logic              ctl_clear,
  input  logic              ctl_auto,
  input  logic              sof_pulse,
  input  logic [CNT_W-1:0]  sof_limit,
  input  logic              miss_clr,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              sof_missing
);
  logic [CNT_W-1:0]  cnt;
  logic              wr_hi;
  logic              wr_lo;
  logic [BYTE_W-1:0] wdata;
  logic              restart;

  assign restart = sof_pulse && ctl_auto;

  sof_byte_port #(.BYTE_W(BYTE_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .wdata     (wdata),
    .rdata     (bus_rdata)
  );

  sof_cnt_core #(.BYTE_W(BYTE_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_run),
    .clr     (ctl_clear),
    .restart (restart),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wdata   (wdata),
    .cnt     (cnt)
  );

  sof_miss_det #(.CNT_W(CNT_W)) u_miss (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_run),
    .cnt      (cnt),
    .limit    (sof_limit),
    .flag_clr (miss_clr),
    .flag     (sof_missing)
  );

  // R8
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse && !ctl_auto && !ctl_run && !ctl_clear && !(bus_en && bus_we))
      |=> $stable(cnt));
endmodule

// File: tb/sof_interval_timer_tb.sv
module sof_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_run = 1'b0;
  logic        ctl_clear = 1'b0;
  logic        ctl_auto = 1'b0;
  logic        sof_pulse = 1'b0;
  logic [15:0] sof_limit = 16'hFFFF;
  logic        miss_clr = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_addr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        sof_missing;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sof_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .ctl_clear(ctl_clear),
    .ctl_auto(ctl_auto), .sof_pulse(sof_pulse), .sof_limit(sof_limit),
    .miss_clr(miss_clr), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sof_missing(sof_missing)
  );

  // fields: run[35] clr[34] sof[33] auto[32] cycles[31:16] expected[15:0]
  localparam logic [35:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd10,  16'd10},   // R2 count
    {1'b0, 1'b0, 1'b0, 1'b1, 16'd5,   16'd10},   // R2 hold
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd300, 16'd310},  // R2 crosses byte
    {1'b1, 1'b1, 1'b0, 1'b1, 16'd1,   16'd0},    // R3 clear beats run
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd3,   16'd3},    // R2
    {1'b1, 1'b0, 1'b1, 1'b1, 16'd1,   16'd0},    // R8 restart
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd2,   16'd2},    // R2
    {1'b1, 1'b0, 1'b1, 1'b0, 16'd1,   16'd3}     // R8 auto off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic run, input logic clr, input logic sof, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctl_run = run;
      ctl_clear = clr;
      sof_pulse = sof && (i == 0);
    end
    @(negedge clk);
    ctl_run = 1'b0;
    ctl_clear = 1'b0;
    sof_pulse = 1'b0;
  endtask

  // starts and ends on a negedge
  task automatic read16(output logic [15:0] val);
    logic [7:0] hi;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 1'b0;
    #1 hi = bus_rdata;
    @(negedge clk);
    bus_addr = 1'b1;
    #1 val = {hi, bus_rdata};
    @(negedge clk);
    bus_en = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic write8(input logic addr, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flag", {31'd0, sof_missing}, 32'd0);
    #1 check("R5 idle rdata", {24'd0, bus_rdata}, 32'd0);
    read16(v);
    check("R1 count and latch", {16'd0, v}, 32'd0);

    // vector table
    for (int k = 0; k < 8; k++) begin
      ctl_auto = VEC[k][32];
      apply(VEC[k][35], VEC[k][34], VEC[k][33], int'(VEC[k][31:16]));
      read16(v);
      check($sformatf("R2/R3/R8 vector %0d", k), {16'd0, v}, {16'd0, VEC[k][15:0]});
      check("R9 no alarm below limit", {31'd0, sof_missing}, 32'd0);
    end

    // R7 byte presets
    write8(1'b0, 8'h12);
    write8(1'b1, 8'h34);
    @(negedge clk);
    read16(v);
    check("R7 preset both bytes", {16'd0, v}, 32'h1234);
    write8(1'b1, 8'h56);
    @(negedge clk);
    read16(v);
    check("R7 low write keeps high", {16'd0, v}, 32'h1256);

    // R7 write beats SOF restart
    ctl_auto = 1'b1;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h77; sof_pulse = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 1'b0; sof_pulse = 1'b0;
    read16(v);
    check("R7 write over restart", {16'd0, v}, 32'h1277);

    // R6 coherent read while running across 0x12FF -> 0x1300
    write8(1'b1, 8'hFF);
    @(negedge clk);
    ctl_run = 1'b1;
    read16(v);
    ctl_run = 1'b0;
    check("R6 coherent pair", {16'd0, v}, 32'h12FF);

    // R4 saturation
    write8(1'b0, 8'hFF);
    write8(1'b1, 8'hFD);
    apply(1'b1, 1'b0, 1'b0, 5);
    read16(v);
    check("R4 saturate", {16'd0, v}, 32'hFFFF);

    // R3 clear beats a write
    @(negedge clk);
    ctl_clear = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'hAA;
    @(negedge clk);
    ctl_clear = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    read16(v);
    check("R3 clear over write", {16'd0, v}, 32'd0);

    // R10 clear alarm (set by saturation above), R9 exact edge
    @(negedge clk);
    miss_clr = 1'b1;
    @(negedge clk);
    miss_clr = 1'b0;
    check("R10 alarm cleared", {31'd0, sof_missing}, 32'd0);
    sof_limit = 16'd20;
    apply(1'b0, 1'b1, 1'b0, 1);
    apply(1'b1, 1'b0, 1'b0, 20);
    check("R9 not yet at limit", {31'd0, sof_missing}, 32'd0);
    apply(1'b1, 1'b0, 1'b0, 1);
    check("R9 alarm set", {31'd0, sof_missing}, 32'd1);
    apply(1'b1, 1'b0, 1'b1, 1);
    check("R9 sticky across SOF", {31'd0, sof_missing}, 32'd1);

    // R10 clear wins over set condition
    @(negedge clk);
    ctl_run = 1'b1; miss_clr = 1'b1;
    write8(1'b0, 8'h40);
    @(negedge clk);
    ctl_run = 1'b0; miss_clr = 1'b0;
    check("R10 clear over set", {31'd0, sof_missing}, 32'd0);

    // R8/R9 regular SOFs keep alarm low
    apply(1'b0, 1'b1, 1'b0, 1);
    for (int f = 0; f < 10; f++) apply(1'b1, 1'b0, 1'b1, 10);
    check("R9 SOFs within limit", {31'd0, sof_missing}, 32'd0);
    read16(v);
    check("R8 count since last SOF", {16'd0, v}, 32'd9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule